// File: doc/BRIEF.md
# Regulator Enable and Voltage-Select Controller

This block is the digital control for one switching regulator channel. It decides whether the channel runs and which 8-bit voltage code is sent to the power stage. A software master enable always has the last word. Below it, the channel runs in one of three ways. In software mode the channel is simply on. In pin mode, one of two external enable pins turns the channel on and off. In roof/floor mode the channel stays on, and the same pin chooses between a normal setpoint and a lower floor setpoint.

The pins are asynchronous. Each pass through a two-flop synchronizer. The pin that is selected then goes to a delay filter. The filter commits a rising level only after a programmable start-up count of 1 ms ticks, and a falling level only after a separate shutdown count. Changes made through the configuration inputs take effect at once, because the outputs are decoded combinationally from them and from the committed pin level.

Top module: `regulator_enable_ctrl`

## Requirements
- R1: When `master_en` is 0, `reg_en` is 0 and `vout_code` is 0, whatever either pin does.
- R2: When `master_en` is 1 and `pin_ctrl` is 0, `reg_en` is 1 and `vout_code` equals `vset`. Pin activity has no effect.
- R3: `pin_sel` = 0 selects `en_pins[0]` and `pin_sel` = 1 selects `en_pins[1]`. Toggling the pin that is not selected changes no output.
- R4: When `pin_ctrl` = 1 and `roof_floor` = 0, a committed low pin level gives `reg_en` = 0 and `vout_code` = 0. A committed high level gives `reg_en` = 1 and `vout_code` = `vset`.
- R5: When `pin_ctrl` = 1 and `roof_floor` = 1, `reg_en` stays 1. A committed low level gives `vout_code` = `floor_vset` and a committed high level gives `vset`.
- R6: After the selected pin goes high, the committed level rises only once `start_dly` ticks of `tick_1ms` have been counted. No ticks means no change.
- R7: After the selected pin goes low, the committed level falls only once `stop_dly` ticks have been counted.
- R8: If the pin returns to its committed level while a count is pending, the pending change is cancelled and the committed level never moves.
- R9: Changes to `master_en`, `pin_ctrl` and `roof_floor` reach the outputs in the same cycle, with no delay.
- R10: With a delay code of 0, a pin change reaches the outputs on the third rising clock edge after the pin moves: two synchronizer stages, then one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| master_en | input | 1 | Software master enable |
| pin_ctrl | input | 1 | 1 = the pin governs the channel |
| pin_sel | input | 1 | Pin chooser (0 = pin 0, 1 = pin 1) |
| roof_floor | input | 1 | 1 = the pin chooses the voltage instead of the enable |
| start_dly | input | 4 | Rising-edge delay in ticks |
| stop_dly | input | 4 | Falling-edge delay in ticks |
| vset | input | 8 | Normal voltage code |
| floor_vset | input | 8 | Floor voltage code |
| en_pins | input | 2 | Asynchronous enable pins |
| reg_en | output | 1 | Regulator enable |
| vout_code | output | 8 | Selected voltage code |

## Verification
Two things can happen in the same cycle: a tick arrives while the delay filter is still loading a count, and a reversing pin edge meets a count that is still in progress. The bench provokes both with a free-running tick set against pin changes. It includes an edge that reverses before its count expires and a code-0 change counted to the exact clock edge. Every cycle, the outputs are compared with a behavioural model that keeps its own synchronizer history and its own pending count.

// File: rtl/regctl_pkg.sv
// Package: shared mode type for the regulator enable controller.
// Assumes: nothing; pure type definitions.
package regctl_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SW   = 2'd1,
        MODE_PIN  = 2'd2,
        MODE_ROOF = 2'd3
    } regctl_mode_e;
endpackage

// File: rtl/regctl_pin_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes: the pins are asynchronous levels; glitches shorter than a clock may be lost.
module regctl_pin_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar g = 0; g < W; g++) begin : g_chain
        // Shift each pin through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[g] <= 1'b0;
                stage2[g] <= 1'b0;
            end else begin
                stage1[g] <= pin_async[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign pin_sync = stage2;
endmodule

// File: rtl/regctl_edge_delay.sv
// Delay filter: commits a new level only after a direction-dependent tick count.
// Assumes: tick is a one-cycle pulse. A code of 0 commits at the first edge that sees
// the mismatch. A return to the committed level cancels a pending count.
module regctl_edge_delay #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             level_in,
    input  logic [DLY_W-1:0] rise_code,
    input  logic [DLY_W-1:0] fall_code,
    output logic             level_q
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic             committed;
    logic             pending;
    logic [DLY_W-1:0] remain;
    logic [DLY_W-1:0] dir_code;

    // Pick the delay code for the direction the input is asking for.
    always_comb dir_code = level_in ? rise_code : fall_code;

    // Track the input, count ticks while pending, and commit when the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            committed <= 1'b0;
            pending   <= 1'b0;
            remain    <= '0;
        end else if (level_in == committed) begin
            pending <= 1'b0;
        end else if (!pending) begin
            if (dir_code == '0) begin
                committed <= level_in;
            end else begin
                pending <= 1'b1;
                remain  <= dir_code;
            end
        end else if (tick) begin
            if (remain == ONE) begin
                committed <= level_in;
                pending   <= 1'b0;
            end else begin
                remain <= remain - ONE;
            end
        end
    end

    assign level_q = committed;

    // R8: the committed level can only move to the value the input holds.
    a_r8_commit_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (committed != $past(committed)) |-> (committed == $past(level_in)));

    // R6: without a tick, a count above one holds its value.
    a_r6_count_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !tick && remain > ONE && level_in != committed) |=> (remain == $past(remain)));

    // R7: an input that differs from a pending commit does not commit before the count expires.
    a_r7_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && remain > ONE) |=> $stable(committed));
endmodule

// File: rtl/regctl_out_select.sv
// Output decode: maps the configuration inputs and the committed pin level to enable and voltage code.
// Assumes: purely combinational, so configuration changes act in the same cycle.
module regctl_out_select
    import regctl_pkg::*;
#(
    parameter int VCODE_W = 8
) (
    input  logic               master_en,
    input  logic               pin_ctrl,
    input  logic               roof_floor,
    input  logic               pin_level,
    input  logic [VCODE_W-1:0] vset,
    input  logic [VCODE_W-1:0] floor_vset,
    output logic               reg_en,
    output logic [VCODE_W-1:0] vout_code
);
    regctl_mode_e mode;

    // Work out the operating mode from the configuration bits.
    always_comb begin
        if (!master_en)      mode = MODE_OFF;
        else if (!pin_ctrl)  mode = MODE_SW;
        else if (roof_floor) mode = MODE_ROOF;
        else                 mode = MODE_PIN;
    end

    // Drive the enable and the voltage code for each mode.
    always_comb begin
        unique case (mode)
            MODE_OFF: begin
                reg_en    = 1'b0;
                vout_code = '0;
            end
            MODE_SW: begin
                reg_en    = 1'b1;
                vout_code = vset;
            end
            MODE_PIN: begin
                reg_en    = pin_level;
                vout_code = pin_level ? vset : '0;
            end
            default: begin
                reg_en    = 1'b1;
                vout_code = pin_level ? vset : floor_vset;
            end
        endcase
    end
endmodule

// File: rtl/regulator_enable_ctrl.sv
// Top: synchronizes the pins, picks one, delays its edges, and decodes the outputs.
// Assumes: tick_1ms is synchronous to clk; the configuration inputs come from registers.
module regulator_enable_ctrl #(
    parameter int VCODE_W  = 8,
    parameter int DLY_W    = 4,
    parameter int NUM_PINS = 2,
    localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_1ms,
    input  logic                master_en,
    input  logic                pin_ctrl,
    input  logic [SEL_W-1:0]    pin_sel,
    input  logic                roof_floor,
    input  logic [DLY_W-1:0]    start_dly,
    input  logic [DLY_W-1:0]    stop_dly,
    input  logic [VCODE_W-1:0]  vset,
    input  logic [VCODE_W-1:0]  floor_vset,
    input  logic [NUM_PINS-1:0] en_pins,
    output logic                reg_en,
    output logic [VCODE_W-1:0]  vout_code
);
    logic [NUM_PINS-1:0] pins_s;
    logic                sel_level;
    logic                committed_level;

    regctl_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (en_pins),
        .pin_sync  (pins_s)
    );

    // Choose the synchronized pin named by the select input.
    always_comb sel_level = pins_s[pin_sel];

    regctl_edge_delay #(.DLY_W(DLY_W)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1ms),
        .level_in  (sel_level),
        .rise_code (start_dly),
        .fall_code (stop_dly),
        .level_q   (committed_level)
    );

    regctl_out_select #(.VCODE_W(VCODE_W)) u_out (
        .master_en  (master_en),
        .pin_ctrl   (pin_ctrl),
        .roof_floor (roof_floor),
        .pin_level  (committed_level),
        .vset       (vset),
        .floor_vset (floor_vset),
        .reg_en     (reg_en),
        .vout_code  (vout_code)
    );

    // R1: master off forces the channel off with a zero code.
    a_r1_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (!reg_en && vout_code == '0));

    // R2: software mode runs at the normal setpoint.
    a_r2_sw_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !pin_ctrl) |-> (reg_en && vout_code == vset));

    // R5: roof/floor mode never turns the channel off.
    a_r5_roof_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && pin_ctrl && roof_floor) |-> reg_en);

    // R4: in pin mode an enabled channel always carries the normal setpoint.
    a_r4_pin_on_uses_vset: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && pin_ctrl && !roof_floor && reg_en) |-> (vout_code == vset));
endmodule

// File: tb/regulator_enable_ctrl_bench.sv
module regulator_enable_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic       master_en = 1'b0;
    logic       pin_ctrl = 1'b0;
    logic [0:0] pin_sel = 1'b0;
    logic       roof_floor = 1'b0;
    logic [3:0] start_dly = 4'd0;
    logic [3:0] stop_dly = 4'd0;
    logic [7:0] vset = 8'h64;
    logic [7:0] floor_vset = 8'h32;
    logic [1:0] en_pins = 2'b00;
    logic       reg_en;
    logic [7:0] vout_code;

    int  checks = 0;
    int  failures = 0;
    bit  tick_on = 1'b0;
    bit  done = 1'b0;
    logic [1:0] tdiv = 2'd0;

    // Behavioural reference state
    bit m_s1 [2];
    bit m_s2 [2];
    bit m_commit = 0;
    bit m_pend = 0;
    int m_cnt = 0;

    regulator_enable_ctrl u_regulator_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .master_en(master_en),
        .pin_ctrl(pin_ctrl), .pin_sel(pin_sel), .roof_floor(roof_floor),
        .start_dly(start_dly), .stop_dly(stop_dly), .vset(vset),
        .floor_vset(floor_vset), .en_pins(en_pins), .reg_en(reg_en),
        .vout_code(vout_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generator: a pulse every fourth cycle while enabled
    always @(posedge clk) begin
        #1;
        tdiv     <= tdiv + 2'd1;
        tick_1ms <= tick_on && (tdiv == 2'd3);
    end

    // Reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1[0] = 0; m_s1[1] = 0; m_s2[0] = 0; m_s2[1] = 0;
            m_commit = 0; m_pend = 0; m_cnt = 0;
        end else begin
            bit lvl;
            int code;
            lvl = pin_sel[0] ? m_s2[1] : m_s2[0];
            if (lvl == m_commit) m_pend = 0;
            else if (!m_pend) begin
                code = lvl ? int'(start_dly) : int'(stop_dly);
                if (code == 0) m_commit = lvl;
                else begin m_pend = 1; m_cnt = code; end
            end else if (tick_1ms) begin
                if (m_cnt == 1) begin m_commit = lvl; m_pend = 0; end
                else m_cnt = m_cnt - 1;
            end
            m_s2[0] = m_s1[0]; m_s2[1] = m_s1[1];
            m_s1[0] = en_pins[0]; m_s1[1] = en_pins[1];
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_en();
        if (!master_en) return 0;
        if (!pin_ctrl) return 1;
        if (roof_floor) return 1;
        return m_commit;
    endfunction

    function automatic int exp_code();
        if (!master_en) return 0;
        if (!pin_ctrl) return int'(vset);
        if (roof_floor) return m_commit ? int'(vset) : int'(floor_vset);
        return m_commit ? int'(vset) : 0;
    endfunction

    // Per-cycle comparison against the model, tagged by mode
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            if (!master_en) tag = "R1";
            else if (!pin_ctrl) tag = "R2";
            else if (roof_floor) tag = "R5";
            else tag = "R4";
            check({tag, " reg_en"}, int'(reg_en), int'(exp_en()));
            check({tag, " vout_code"}, int'(vout_code), exp_code());
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        check("R1 reset reg_en", int'(reg_en), 0);
        check("R1 reset vout_code", int'(vout_code), 0);
        rst_n = 1'b1;
        // R1: pins toggle while master is off
        en_pins = 2'b11; pin_ctrl = 1'b1; step(6);
        check("R1 pins ignored", int'(reg_en), 0);
        en_pins = 2'b00; step(6);
        // R9 + R2: software enable acts in the same cycle
        pin_ctrl = 1'b0; master_en = 1'b1; #1;
        check("R9 immediate enable", int'(reg_en), 1);
        check("R2 code", int'(vout_code), 8'h64);
        en_pins = 2'b11; step(5);
        check("R2 pins ignored", int'(reg_en), 1);
        en_pins = 2'b00; step(5);
        // R10: code 0 rise counted to the edge
        pin_ctrl = 1'b1; #1;
        check("R9 immediate pin mode", int'(reg_en), 0);
        en_pins[0] = 1'b1; step(2);
        check("R10 before third edge", int'(reg_en), 0);
        step(1);
        check("R10 at third edge", int'(reg_en), 1);
        // R7: falling edge needs stop_dly ticks
        stop_dly = 4'd2; en_pins[0] = 1'b0; step(12);
        check("R7 held without ticks", int'(reg_en), 1);
        tick_on = 1'b1; step(12);
        check("R7 off after ticks", int'(reg_en), 0);
        // R6: rise with start_dly and no ticks
        tick_on = 1'b0; start_dly = 4'd3; en_pins[0] = 1'b1; step(12);
        check("R6 held without ticks", int'(reg_en), 0);
        tick_on = 1'b1; step(16);
        check("R6 on after ticks", int'(reg_en), 1);
        // R8: reversal during a pending shutdown cancels it
        stop_dly = 4'd5; en_pins[0] = 1'b0; step(6);
        en_pins[0] = 1'b1; step(40);
        check("R8 cancelled shutdown", int'(reg_en), 1);
        // R3: select pin 1; toggling pin 0 has no effect
        stop_dly = 4'd1; start_dly = 4'd1; pin_sel = 1'b1; step(12);
        check("R3 pin1 low selected", int'(reg_en), 0);
        en_pins[0] = 1'b0; step(8); en_pins[0] = 1'b1; step(8);
        check("R3 unselected ignored", int'(reg_en), 0);
        en_pins[1] = 1'b1; step(12);
        check("R3 pin1 high selected", int'(reg_en), 1);
        // R5: roof/floor with delays
        roof_floor = 1'b1; en_pins[1] = 1'b0; step(12);
        check("R5 floor code", int'(vout_code), 8'h32);
        check("R5 still enabled", int'(reg_en), 1);
        en_pins[1] = 1'b1; step(12);
        check("R5 roof code", int'(vout_code), 8'h64);
        // Ticks and edges interleaved at varied phases
        start_dly = 4'd2; stop_dly = 4'd3; roof_floor = 1'b0;
        for (int k = 0; k < 30; k++) begin
            en_pins[1] = ~en_pins[1];
            step(3 + (k % 7) * 2);
        end
        // R9: master off acts in the same cycle
        master_en = 1'b0; #1;
        check("R9 immediate disable", int'(reg_en), 0);
        step(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule